// File: doc/BRIEF.md
# Delay-Insensitive Two-Wire Serial Receiver

This block is the listening side of a two-wire, fully interlocked serial link between two controllers that may each stall for an unbounded time. Each bit travels as a four-phase handshake. The sender pulls one of the two shared open-drain lines to signal the bit value. The receiver answers on the other line. The sender then lets its line go, and the receiver lets its answer go. No phase has a time limit, so a slow party only slows the link and never corrupts it.

The receiver turns the stream of handshaken bits into bytes. A byte frame is a zero start bit followed by eight data bits. One bits that arrive while no frame is open are idle filler and are discarded. A one that arrives in the start-bit slot after at least one byte of the current message marks the end of that message. Each finished byte appears with a single-cycle valid strobe. The end of a message is reported with a single-cycle pulse. A malformed line state, with both lines pulled while a bit is awaited, is reported on an error pulse.

The line inputs are asynchronous and pass through a flop synchronizer. The line outputs are pull-down enables for external open-drain drivers. Addressing, storage of more than one byte, and the reply turnaround are left to the surrounding logic.

Top module: `twr_rx`

## Requirements
- R1: A zero is signalled when line A alone reads asserted (input at 1). The receiver answers by setting `driveB` and leaving `driveA` clear. It clears `driveB` once line A reads released (input at 0).
- R2: A one is signalled when line B alone reads asserted. The receiver answers by setting `driveA` and leaving `driveB` clear. It clears `driveA` once line B reads released.
- R3: `driveA` and `driveB` are never set together. No new bit is taken until the receiver's own answer release has passed through the synchronizer.
- R4: One bits received while no frame is open, and before any byte of a message, produce no byte strobe and no end-of-message pulse.
- R5: A zero received while no frame is open starts a frame. The next eight bits form the byte, with the first of them in bit 0 and the eighth in bit 7.
- R6: `byteValid` is high for exactly one cycle. It rises in the cycle the eighth data bit's answer is withdrawn, so both drives are clear while it is high. `byteData` changes only together with `byteValid`.
- R7: A one received in the start-bit slot after at least one byte of the message gives a one-cycle `endOfMsg` pulse. Further idle ones then give no pulse until another byte has been received.
- R8: The sender may hold each phase for any number of cycles without a bit being lost or taken twice.
- R9: If both lines read asserted while a bit is awaited, `protoErr` pulses for one cycle and no bit is recorded. No answer is driven, and no new bit is taken until both lines read released.
- R10: After reset both drives are clear and `byteValid`, `endOfMsg` and `protoErr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineAIn | input | 1 | Sensed level of line A, 1 = pulled (asserted) |
| lineBIn | input | 1 | Sensed level of line B, 1 = pulled (asserted) |
| driveA | output | 1 | Pull-down enable for line A |
| driveB | output | 1 | Pull-down enable for line B |
| byteValid | output | 1 | One-cycle strobe for a completed byte |
| byteData | output | 8 | Last completed byte, bit 0 received first |
| endOfMsg | output | 1 | One-cycle end-of-message pulse |
| protoErr | output | 1 | One-cycle pulse on both lines asserted |

## Verification
The bench goes after the start-slot decisions first. A design that treats idle ones as data, or that reports an end of message before any byte, fires `endOfMsg` or `byteValid` during leading filler. The bench also checks the turnaround just after an answer is withdrawn. If the synchronizer echo of the receiver's own answer is read as a fresh bit, the design accepts a phantom bit, which shifts or duplicates bits and corrupts the next byte. Long and zero-length phase holds expose a design that depends on timing and drops bits. Finally, a double-asserted line state checks that the design neither answers nor shifts in a bit, since either would misalign the frame that follows.

// File: rtl/twr_pkg.sv
package twr_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;   // shift one data bit into the assembly register
    logic clearCnt;  // start bit seen: restart the data bit count
    logic loadByte;  // last data bit: publish the byte
    logic bitVal;    // value of the bit just completed
  } rxStrobeT;

  typedef enum logic [2:0] {
    ST_QUIET,     // wait for both lines released
    ST_WAIT_BIT,  // wait for the sender to pull a line
    ST_ACK_ZERO,  // answering a zero on line B
    ST_ACK_ONE,   // answering a one on line A
    ST_DRAIN      // let own answer release pass the synchronizer
  } hsStateT;

endpackage

// File: rtl/twr_rx_sync.sv
module twr_rx_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] syncOut
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/twr_rx_ctrl.sv
module twr_rx_ctrl
  import twr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     aSync,
  input  logic     bSync,
  input  logic     lastBit,
  output rxStrobeT strobe,
  output logic     driveA,
  output logic     driveB,
  output logic     endOfMsg,
  output logic     protoErr
);

  localparam int DRAIN_W = $clog2(SYNC_STAGES + 1);
  localparam logic [DRAIN_W-1:0] DRAIN_LAST = DRAIN_W'(SYNC_STAGES - 1);

  hsStateT state, stateNxt;
  logic [DRAIN_W-1:0] drainCnt;
  logic inByte, gotByte;
  logic bitDone, bitVal, errNow, eomNow;

  assign driveA = (state == ST_ACK_ONE);
  assign driveB = (state == ST_ACK_ZERO);

  // A bit is complete when the sender withdraws its line
  assign bitDone = ((state == ST_ACK_ZERO) && !aSync) ||
                   ((state == ST_ACK_ONE)  && !bSync);
  assign bitVal  = (state == ST_ACK_ONE);
  assign errNow  = (state == ST_WAIT_BIT) && aSync && bSync;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_QUIET:    if (!aSync && !bSync) stateNxt = ST_WAIT_BIT;
      ST_WAIT_BIT: begin
        if (aSync && bSync) stateNxt = ST_QUIET;
        else if (aSync)     stateNxt = ST_ACK_ZERO;
        else if (bSync)     stateNxt = ST_ACK_ONE;
      end
      ST_ACK_ZERO: if (!aSync) stateNxt = ST_DRAIN;
      ST_ACK_ONE:  if (!bSync) stateNxt = ST_DRAIN;
      ST_DRAIN:    if (drainCnt == DRAIN_LAST) stateNxt = ST_WAIT_BIT;
      default:     stateNxt = ST_QUIET;
    endcase
  end

  // Framing decisions on each completed bit
  always_comb begin
    strobe        = '0;
    strobe.bitVal = bitVal;
    eomNow        = 1'b0;
    if (bitDone) begin
      if (inByte) begin
        if (lastBit) strobe.loadByte = 1'b1;
        else         strobe.shiftEn  = 1'b1;
      end else if (!bitVal) begin
        strobe.clearCnt = 1'b1;
      end else if (gotByte) begin
        eomNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_QUIET;
      drainCnt <= '0;
      inByte   <= 1'b0;
      gotByte  <= 1'b0;
      endOfMsg <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      state    <= stateNxt;
      drainCnt <= (state == ST_DRAIN) ? drainCnt + 1'b1 : '0;
      endOfMsg <= eomNow;
      protoErr <= errNow;
      if (strobe.clearCnt) inByte <= 1'b1;
      if (strobe.loadByte) begin
        inByte  <= 1'b0;
        gotByte <= 1'b1;
      end
      if (eomNow) gotByte <= 1'b0;
    end
  end

  a_r1_zero_ack_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveB) |-> $past(aSync) && !$past(bSync));
  a_r1_zero_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveB) |-> !$past(aSync));
  a_r2_one_ack_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveA) |-> $past(bSync) && !$past(aSync));
  a_r2_one_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveA) |-> !$past(bSync));
  a_r3_exclusive_drive: assert property (@(posedge clk) disable iff (!rstN)
    !(driveA && driveB));
  a_r7_eom_single: assert property (@(posedge clk) disable iff (!rstN)
    endOfMsg |=> !endOfMsg);
  a_r9_err_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !driveA && !driveB);

endmodule

// File: rtl/twr_rx_datapath.sv
module twr_rx_datapath
  import twr_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobeT             strobe,
  output logic                 lastBit,
  output logic                 byteValid,
  output logic [DATA_BITS-1:0] byteData
);

  localparam int CNT_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_BITS - 1);

  logic [DATA_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]     bitCnt;

  assign lastBit = (bitCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= strobe.loadByte;
      if (strobe.clearCnt) bitCnt <= '0;
      if (strobe.shiftEn) begin
        shiftReg <= {strobe.bitVal, shiftReg[DATA_BITS-1:1]};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (strobe.loadByte) byteData <= {strobe.bitVal, shiftReg[DATA_BITS-1:1]};
    end
  end

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |-> bitCnt < CNT_LAST);
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  a_r6_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(byteData));

endmodule

// File: rtl/twr_rx.sv
module twr_rx
  import twr_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineAIn,
  input  logic                 lineBIn,
  output logic                 driveA,
  output logic                 driveB,
  output logic                 byteValid,
  output logic [DATA_BITS-1:0] byteData,
  output logic                 endOfMsg,
  output logic                 protoErr
);

  logic [1:0] lineSync;
  rxStrobeT   strobe;
  logic       lastBit;

  twr_rx_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .rawIn  ({lineBIn, lineAIn}),
    .syncOut(lineSync)
  );

  twr_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .aSync   (lineSync[0]),
    .bSync   (lineSync[1]),
    .lastBit (lastBit),
    .strobe  (strobe),
    .driveA  (driveA),
    .driveB  (driveB),
    .endOfMsg(endOfMsg),
    .protoErr(protoErr)
  );

  twr_rx_datapath #(.DATA_BITS(DATA_BITS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lastBit  (lastBit),
    .byteValid(byteValid),
    .byteData (byteData)
  );

endmodule

// File: tb/twr_rx_tb_top.sv
module twr_rx_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sendA = 1'b0, sendB = 1'b0;
  logic driveA, driveB, byteValid, endOfMsg, protoErr;
  logic [7:0] byteData;

  always #2 clk = ~clk;  // 250 MHz

  // Wired lines: pulled if either party pulls
  twr_rx dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineAIn  (sendA | driveA),
    .lineBIn  (sendB | driveB),
    .driveA   (driveA),
    .driveB   (driveB),
    .byteValid(byteValid),
    .byteData (byteData),
    .endOfMsg (endOfMsg),
    .protoErr (protoErr)
  );

  typedef struct packed {
    logic [7:0] data;
    logic [3:0] gap;
    logic       endMsg;
  } vecT;

  localparam int NVEC = 6;
  localparam vecT VEC [NVEC] = '{
    '{8'hA5, 4'd0,  1'b0},
    '{8'h01, 4'd3,  1'b1},
    '{8'h80, 4'd15, 1'b0},
    '{8'hFF, 4'd1,  1'b0},
    '{8'h00, 4'd7,  1'b0},
    '{8'h3C, 4'd2,  1'b1}
  };

  int checks = 0, errors = 0;
  int rxCnt = 0, eomCnt = 0, errCnt = 0, bothDrive = 0, dupValid = 0, busyValid = 0;
  logic [7:0] rxLog [64];
  logic prevValid = 1'b0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        if (rxCnt < 64) rxLog[rxCnt] = byteData;
        rxCnt++;
        if (driveA || driveB) busyValid++;
        if (prevValid) dupValid++;
      end
      prevValid = byteValid;
      if (endOfMsg) eomCnt++;
      if (protoErr) errCnt++;
      if (driveA && driveB) bothDrive++;
    end
  end

  task automatic sendBit(input logic b, input int gap);
    int t;
    t = 0;
    while ((driveA || driveB) && t < 2000) begin @(negedge clk); t++; end
    if (b) sendB = 1'b1; else sendA = 1'b1;
    t = 0;
    while (!(b ? driveA : driveB) && t < 2000) begin @(negedge clk); t++; end
    // R1 / R2: answer on the opposite line only
    if (b) check(driveA && !driveB, "R2 ack one", {driveA, driveB}, 2'b10);
    else   check(driveB && !driveA, "R1 ack zero", {driveA, driveB}, 2'b01);
    repeat (gap) @(negedge clk);
    sendA = 1'b0; sendB = 1'b0;
    t = 0;
    while ((b ? driveA : driveB) && t < 2000) begin @(negedge clk); t++; end
    check(!(driveA || driveB), "R1/R2 ack release", {driveA, driveB}, 2'b00);
    repeat (gap) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input int gap);
    sendBit(1'b0, gap);
    for (int i = 0; i < 8; i++) sendBit(d[i], gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!driveA && !driveB, "R10 drives", {driveA, driveB}, 0);
    check(!byteValid, "R10 byteValid", byteValid, 0);
    check(!endOfMsg && !protoErr, "R10 pulses", {endOfMsg, protoErr}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R4: leading idle ones are ignored
    for (int i = 0; i < 3; i++) sendBit(1'b1, 1);
    repeat (6) @(negedge clk);
    check(rxCnt == 0, "R4 no byte from idle ones", rxCnt, 0);
    check(eomCnt == 0, "R4 no end before a byte", eomCnt, 0);

    // R5 / R8 / R7: table of frames
    for (int v = 0; v < NVEC; v++) begin
      int base, eomBase;
      base = rxCnt;
      eomBase = eomCnt;
      sendByte(VEC[v].data, int'(VEC[v].gap));
      repeat (3) @(negedge clk);
      check(rxCnt == base + 1, "R8 one byte per frame", rxCnt, base + 1);
      check(rxLog[base] == VEC[v].data, "R5 byte value", rxLog[base], VEC[v].data);
      if (VEC[v].endMsg) begin
        sendBit(1'b1, int'(VEC[v].gap));
        repeat (3) @(negedge clk);
        check(eomCnt == eomBase + 1, "R7 end of message", eomCnt, eomBase + 1);
      end
    end

    // R7: further ones after the end give no pulse
    begin
      int e0;
      e0 = eomCnt;
      sendBit(1'b1, 0);
      sendBit(1'b1, 2);
      repeat (4) @(negedge clk);
      check(eomCnt == e0, "R7 idle ones after end", eomCnt, e0);
    end

    // R9: both lines asserted while waiting
    begin
      int r0, noAck;
      r0 = rxCnt;
      noAck = 1;
      repeat (4) @(negedge clk);
      sendA = 1'b1; sendB = 1'b1;
      repeat (10) begin
        @(negedge clk);
        if (driveA || driveB) noAck = 0;
      end
      check(noAck == 1, "R9 no ack on error", noAck, 1);
      check(errCnt == 1, "R9 error pulse", errCnt, 1);
      sendA = 1'b0; sendB = 1'b0;
      repeat (6) @(negedge clk);
      sendByte(8'h5A, 1);
      sendBit(1'b1, 1);
      repeat (4) @(negedge clk);
      check(rxCnt == r0 + 1, "R9 no phantom bit count", rxCnt, r0 + 1);
      check(rxLog[r0] == 8'h5A, "R9 next byte intact", rxLog[r0], 8'h5A);
    end

    // R6 / R3: monitor findings
    check(dupValid == 0, "R6 single-cycle strobe", dupValid, 0);
    check(busyValid == 0, "R6 strobe after release", busyValid, 0);
    check(bothDrive == 0, "R3 exclusive drives", bothDrive, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule